// File: doc/BRIEF.md
# Periodic and Single-Shot Interval Timer

This block is a timer peripheral seen by software through a 16-bit register port. A 32-bit up-counter advances once per prescaler period. It is compared against a 32-bit terminal value, and both 32-bit quantities are reached as pairs of 16-bit registers. Software picks continuous operation or a single run with two separate control bits. Every terminal-count event sets a sticky pending flag, and that flag drives a level interrupt when the interrupt-enable bit is set.

In continuous mode the counter steps from zero up to the terminal value and then returns to zero. With the terminal value at all ones it is a free-running time base that wraps at 2^32. In single-shot mode the counter stops at the terminal value and the run bit clears itself. Programmed intervals shorter than three counter ticks are not promised to be exact. A coherent 32-bit count is read by taking the low half first and then the high half.

Top module: `tick_timer`

Register map, as byte offsets on `addr`:

| Offset | Register |
|---|---|
| 0x00 | control |
| 0x08 | terminal value, low half |
| 0x0C | terminal value, high half |
| 0x10 | count, low half |
| 0x14 | count, high half (latched copy) |
| 0x18 | prescaler |

Control bits: bit 0 is continuous run, bit 1 is single shot, bit 8 is interrupt enable. Bit 15 reads as the pending flag; writing 1 to bit 15 clears that flag.

## Requirements
- R1: After reset every register (control at 0x00, terminal halves at 0x08 and 0x0C, count halves at 0x10 and 0x14, prescaler at 0x18) reads 0, `irq` is low, the counter is stopped and the prescaler divides by one.
- R2: A control write with bits 0 and 1 both zero stops the counter on that same clock edge, and the count then holds its value.
- R3: With prescaler value P (register 0x18), the counter advances once every P+1 clocks.
- R4: With control bit 0 set, the counter steps up to the terminal value, which is the high half (0x0C) joined to the low half (0x08). On the next tick it returns to 0 and raises an event.
- R5: With control bit 1 set and bit 0 clear, the counter stops at the terminal value and raises one event, and control bit 1 then reads 0.
- R6: An event sets a sticky pending flag, which reads as control bit 15. Writing control with bit 15 = 1 clears the flag. If an event falls on the same edge as a clearing write, the flag stays set.
- R7: `irq` is high exactly when the pending flag and control bit 8 are both set. It changes on the edge after the state change that causes it.
- R8: A control write that sets bit 0 or bit 1 while the timer is stopped restarts the count and the prescaler phase from 0.
- R9: A read of 0x10 returns count bits 15:0 and copies count bits 31:16 into a latch. A read of 0x14 returns that latch, so a low-then-high read gives one coherent 32-bit value.
- R10: Read data appears on `rdata` the clock after `rd_en`. The terminal halves and the prescaler read back as they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The two functions that can meet on one clock edge are a terminal-count event and a software write that clears the pending flag. The bench sets up a continuous run with a short terminal value and counts clocks from the start edge. It then issues a clearing write to the control register that lands on the same edge as the counter's wrap. The control register read that follows must still show the pending flag, because the event has priority over the clear. A second clearing write away from any event must drop the flag.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Byte offsets of the registers; software decodes these.
  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_MAX_LO = 'h08;
  localparam int OFF_MAX_HI = 'h0C;
  localparam int OFF_CNT_LO = 'h10;
  localparam int OFF_CNT_HI = 'h14;
  localparam int OFF_DIV    = 'h18;

  // Control bit positions.
  localparam int B_RUN  = 0;
  localparam int B_SHOT = 1;
  localparam int B_IEN  = 8;
  localparam int B_PEND = 15;

  typedef struct packed {
    logic pend;
    logic ien;
    logic shot;
    logic run;
  } tmr_state_t;

endpackage

// File: rtl/tt_prescale.sv
module tt_prescale #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             restart,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);

  logic [PRE_W-1:0] phase_q;

  // ">=" keeps the divider bounded if the ratio shrinks while running.
  always_comb tick = active && (phase_q >= div);

  always_ff @(posedge clk) begin
    if (rst || restart || !active) begin
      phase_q <= '0;
    end else if (tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/tt_core.sv
module tt_core
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic             wr_run,
  input  logic             wr_shot,
  input  logic             wr_ien,
  input  logic             wr_clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] max_val,
  output tmr_state_t       st,
  output logic [CNT_W-1:0] cnt,
  output logic             active,
  output logic             restart,
  output logic             irq
);

  tmr_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q;
  logic             wr_go, halt, step, evt;

  always_comb begin
    active  = st_q.run | st_q.shot;
    wr_go   = wr_run | wr_shot;
    restart = ctrl_we && !active && wr_go;
    halt    = ctrl_we && !wr_go;
    step    = active && tick && !halt;
    evt     = step && (cnt_q == max_val);

    st_d.run  = ctrl_we ? wr_run  : st_q.run;
    st_d.shot = (ctrl_we ? wr_shot : st_q.shot) & ~evt;
    st_d.ien  = ctrl_we ? wr_ien  : st_q.ien;
    // Event has priority over a clear on the same edge.
    st_d.pend = (st_q.pend & ~(ctrl_we & wr_clr)) | evt;

    if (restart) begin
      cnt_d = '0;
    end else if (evt) begin
      cnt_d = st_d.run ? '0 : cnt_q;
    end else if (step) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      irq_q <= st_d.pend & st_d.ien;
    end
  end

  assign st  = st_q;
  assign cnt = cnt_q;
  assign irq = irq_q;

endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  tmr_state_t        st,
  output logic              ctrl_we,
  output logic              wr_run,
  output logic              wr_shot,
  output logic              wr_ien,
  output logic              wr_clr,
  output logic [CNT_W-1:0]  max_val,
  output logic [BUS_W-1:0]  div_val,
  output logic [BUS_W-1:0]  rdata
);

  localparam int HALVES = CNT_W / BUS_W;
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_MAX_LO = ADDR_W'(OFF_MAX_LO);
  localparam logic [ADDR_W-1:0] A_MAX_HI = ADDR_W'(OFF_MAX_HI);
  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFF_CNT_LO);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFF_CNT_HI);
  localparam logic [ADDR_W-1:0] A_DIV    = ADDR_W'(OFF_DIV);

  logic [HALVES-1:0][BUS_W-1:0] max_h;
  logic [BUS_W-1:0]             div_q, shadow_q, rdata_q, ctrl_rd;

  always_comb begin
    ctrl_we = wr_en && (addr == A_CTRL);
    wr_run  = wdata[B_RUN];
    wr_shot = wdata[B_SHOT];
    wr_ien  = wdata[B_IEN];
    wr_clr  = wdata[B_PEND];
  end

  // Terminal value: one 16-bit register per half.
  for (genvar h = 0; h < HALVES; h++) begin : g_max
    localparam logic [ADDR_W-1:0] A_HALF = (h == 0) ? A_MAX_LO : A_MAX_HI;
    always_ff @(posedge clk) begin
      if (rst) begin
        max_h[h] <= '0;
      end else if (wr_en && addr == A_HALF) begin
        max_h[h] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (wr_en && addr == A_DIV) begin
      div_q <= wdata;
    end
  end

  always_comb begin
    ctrl_rd         = '0;
    ctrl_rd[B_RUN]  = st.run;
    ctrl_rd[B_SHOT] = st.shot;
    ctrl_rd[B_IEN]  = st.ien;
    ctrl_rd[B_PEND] = st.pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      shadow_q <= '0;
    end else if (rd_en) begin
      case (addr)
        A_CTRL:   rdata_q <= ctrl_rd;
        A_MAX_LO: rdata_q <= max_h[0];
        A_MAX_HI: rdata_q <= max_h[HALVES-1];
        A_CNT_LO: begin
          rdata_q  <= cnt[BUS_W-1:0];
          shadow_q <= cnt[CNT_W-1:CNT_W-BUS_W];
        end
        A_CNT_HI: rdata_q <= shadow_q;
        A_DIV:    rdata_q <= div_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign max_val = max_h;
  assign div_val = div_q;
  assign rdata   = rdata_q;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              irq
);

  localparam int CNT_W = 2 * BUS_W;

  tmr_state_t       st_w;
  logic [CNT_W-1:0] cnt_w, max_w;
  logic [BUS_W-1:0] div_w;
  logic             ctrl_we, wr_run, wr_shot, wr_ien, wr_clr;
  logic             tick_w, active_w, restart_w;

  tt_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt_w), .st(st_w), .ctrl_we(ctrl_we),
    .wr_run(wr_run), .wr_shot(wr_shot), .wr_ien(wr_ien), .wr_clr(wr_clr),
    .max_val(max_w), .div_val(div_w), .rdata(rdata)
  );

  tt_prescale #(.PRE_W(BUS_W)) u_pre (
    .clk(clk), .rst(rst), .active(active_w), .restart(restart_w),
    .div(div_w), .tick(tick_w)
  );

  tt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .wr_run(wr_run),
    .wr_shot(wr_shot), .wr_ien(wr_ien), .wr_clr(wr_clr), .tick(tick_w),
    .max_val(max_w), .st(st_w), .cnt(cnt_w), .active(active_w),
    .restart(restart_w), .irq(irq)
  );

endmodule

// File: rtl/tt_checker.sv
module tt_checker
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        wr_go,
  input logic              wr_clr,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input tmr_state_t        st
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

  logic cwr;
  assign cwr = wr_en && (addr == A_CTRL);

  AST_HALT_NOW: assert property (@(posedge clk) disable iff (rst)
    (cwr && wr_go == 2'b00) |=> $stable(cnt)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!st.run && !st.shot && !cwr) |=> $stable(cnt)); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (st.run && !cwr) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1) || cnt == '0)); // R4

  AST_SHOT_DONE: assert property (@(posedge clk) disable iff (rst)
    ($fell(st.shot) && !$past(cwr)) |-> st.pend); // R5

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (st.pend && !(cwr && wr_clr)) |=> st.pend); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> (st.pend && st.ien)); // R7

  AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cwr && !st.run && !st.shot && wr_go != 2'b00) |=> (cnt == '0)); // R8

endmodule

bind tick_timer tt_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_go(wdata[1:0]),
  .wr_clr(wdata[15]), .irq(irq), .cnt(cnt_w), .st(st_w)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {prescaler, terminal value, wait clocks, expected count}
  localparam logic [95:0] VEC [NV] = '{
    {16'd0, 32'd100, 16'd10, 32'd10},
    {16'd2, 32'd100, 16'd10, 32'd3},
    {16'd8, 32'd100, 16'd45, 32'd5},
    {16'd0, 32'd5,   16'd13, 32'd1},
    {16'd3, 32'd2,   16'd26, 32'd0},
    {16'd1, 32'd7,   16'd40, 32'd4}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  tick_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, {16'h0, v}, {16'h0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] lo, hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd_chk("R1 ctrl", 5'h00, 16'h0);
    rd_chk("R1 maxlo", 5'h08, 16'h0);
    rd_chk("R1 maxhi", 5'h0C, 16'h0);
    rd_chk("R1 cntlo", 5'h10, 16'h0);
    rd_chk("R1 cnthi", 5'h14, 16'h0);
    rd_chk("R1 div", 5'h18, 16'h0);

    // R3 / R4 table of periodic runs
    for (int i = 0; i < NV; i++) begin
      wr(5'h00, 16'h8000);
      wr(5'h18, VEC[i][95:80]);
      wr(5'h08, VEC[i][63:48]);
      wr(5'h0C, VEC[i][79:64]);
      wr(5'h00, 16'h0001);
      repeat (int'(VEC[i][47:32])) @(negedge clk);
      rd(5'h10, lo);
      rd(5'h14, hi);
      chk($sformatf("R3 R4 vector %0d", i), {hi, lo}, VEC[i][31:0]);
    end

    // R2 immediate stop
    wr(5'h00, 16'h8000);
    wr(5'h18, 16'd0);
    wr(5'h08, 16'd1000);
    wr(5'h0C, 16'd0);
    wr(5'h00, 16'h0001);
    repeat (5) @(negedge clk);
    wr(5'h00, 16'h0000);
    rd_chk("R2 stop value", 5'h10, 16'd5);
    repeat (20) @(negedge clk);
    rd_chk("R2 held", 5'h10, 16'd5);

    // R5 single shot with interrupt enabled, R7 irq
    wr(5'h08, 16'd4);
    wr(5'h00, 16'h0102);
    repeat (20) @(negedge clk);
    rd_chk("R5 ctrl after shot", 5'h00, 16'h8100);
    chk("R7 irq on", {31'h0, irq}, 32'h1);
    rd_chk("R5 stopped at max", 5'h10, 16'd4);

    // R6 clear
    wr(5'h00, 16'h8100);
    rd_chk("R6 cleared", 5'h00, 16'h0100);
    chk("R7 irq off after clear", {31'h0, irq}, 32'h0);

    // R7 gating
    wr(5'h00, 16'h0002);
    repeat (20) @(negedge clk);
    rd_chk("R7 pending without enable", 5'h00, 16'h8000);
    chk("R7 irq masked", {31'h0, irq}, 32'h0);
    wr(5'h00, 16'h0100);
    chk("R7 irq unmasked", {31'h0, irq}, 32'h1);

    // R6 clear colliding with a periodic event (terminal 9, event edge 10)
    wr(5'h00, 16'h8000);
    wr(5'h08, 16'd9);
    wr(5'h00, 16'h0001);
    repeat (9) @(negedge clk);
    wr(5'h00, 16'h8001);
    rd_chk("R6 event beats clear", 5'h00, 16'h8001);
    wr(5'h00, 16'h8001);
    rd_chk("R6 clear away from event", 5'h00, 16'h0001);

    // R8 restart from stopped resets counter
    wr(5'h00, 16'h8000);
    wr(5'h08, 16'd100);
    wr(5'h18, 16'd3);
    wr(5'h00, 16'h0001);
    repeat (10) @(negedge clk);
    wr(5'h00, 16'h0000);
    rd_chk("R8 before restart", 5'h10, 16'd2);
    wr(5'h00, 16'h0001);
    repeat (3) @(negedge clk);
    rd_chk("R8 restarted zero", 5'h10, 16'd0);
    rd_chk("R8 first tick", 5'h10, 16'd1);

    // R9 coherent read across a carry into the high half
    wr(5'h00, 16'h0000);
    wr(5'h18, 16'd0);
    wr(5'h08, 16'hFFFF);
    wr(5'h0C, 16'hFFFF);
    wr(5'h00, 16'h0001);
    repeat (65535) @(negedge clk);
    rd_chk("R9 low half", 5'h10, 16'hFFFF);
    rd_chk("R9 latched high half", 5'h14, 16'h0000);

    // R10 readback
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'h5678);
    wr(5'h0C, 16'h1234);
    wr(5'h18, 16'h0007);
    rd_chk("R10 maxlo", 5'h08, 16'h5678);
    rd_chk("R10 maxhi", 5'h0C, 16'h1234);
    rd_chk("R10 div", 5'h18, 16'h0007);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule